// File: doc/BRIEF.md
# UART Interrupt Source Prioritizer

This block sits beside the receive, transmit and modem-line logic of a 16550-style serial port. It gathers their pending conditions into one interrupt request and one 8-bit identification byte. Each cycle it looks at the line error bits, the character-timeout flag, the receive data-ready flag together with the FIFO fill level and trigger level, its own transmit-empty pending state and the modem delta bits. It picks the most urgent source that is enabled and encodes it. Software reads the identification byte to find out why the request is asserted.

The block holds two pieces of state. The first is the 4-bit enable register. The second is a two-state tracker that records whether a transmit-empty interrupt is pending. The tracker is set in three cases: when the transmitter reports that its holding register has drained, when the enable register is written while the holding register is empty, or both. It is cleared in two cases: when new data is written to the holding register, or when software reads the identification byte while that byte shows the transmit-empty code.

The tracker states are `TXE_IDLE` and `TXE_PENDING`. The transition `IDLE->PENDING` is taken on a set event. The transition `PENDING->IDLE` is taken on a clear event with no set event in the same cycle. The source selector yields one of `SRC_NONE`, `SRC_LINE`, `SRC_TMO`, `SRC_RXD`, `SRC_TXE` or `SRC_MDM`.

Top module: `uart_iid_prio`

## Requirements
- R1: After reset the identification byte reads 0x01, `irq` is low, the enable register reads 0 and no transmit-empty interrupt is pending.
- R2: With several sources active, exactly one is reported, in the order line status, character timeout, received data, transmit empty, modem status (highest first).
- R3: Bits 3:0 of the identification byte read 0x6 (line status), 0xC (timeout), 0x4 (received data), 0x2 (transmit empty), 0x0 (modem) or 0x1 (nothing pending).
- R4: The line-status source is active only when enable bit 2 is set and at least one of the four `line_err` bits is set.
- R5: The character-timeout source is gated by enable bit 0 (the received-data enable); no other enable bit affects it.
- R6: The received-data source needs enable bit 0 and `rx_ready`. While `fifo_en` is high it also needs `rx_count >= rx_trig`.
- R7: Bits 7:6 of the identification byte read 11 while `fifo_en` is high and 00 otherwise. Bits 5:4 read 0.
- R8: A read strobe taken while the byte shows code 0x2 clears the transmit-empty pending state by the next cycle. A read strobe taken while any other code is shown leaves that state unchanged.
- R9: A write to the enable register stores bits 3:0 of the write data and drops bits 7:4. If `thr_empty` is high in that cycle, the transmit-empty pending state is set.
- R10: The modem-status source needs enable bit 3 and at least one of the four `modem_delta` bits.
- R11: `irq` is high exactly when bits 3:0 of the identification byte differ from 0x1, in the same cycle.
- R12: `txe_raise` sets the pending state and `txe_drop` clears it. When a set and a clear event occur in the same cycle, the state ends up pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ier_wr | input | 1 | Enable-register write strobe |
| ier_wdata | input | 8 | Enable-register write data |
| iir_rd | input | 1 | Identification-byte read strobe |
| line_err | input | 4 | Overrun, parity, framing, break status bits |
| rx_ready | input | 1 | Receive data ready |
| char_tmo | input | 1 | Character-timeout pending |
| rx_count | input | CNT_W | Receive FIFO fill level |
| rx_trig | input | CNT_W | Receive FIFO trigger level |
| thr_empty | input | 1 | Transmit holding register is empty |
| txe_raise | input | 1 | Transmitter drained the holding register |
| txe_drop | input | 1 | Holding register was written |
| modem_delta | input | 4 | Modem-line change bits |
| fifo_en | input | 1 | FIFOs enabled |
| ier_q | output | 4 | Enable register contents |
| iir_q | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request |

## Verification
The bench stacks every source at once and removes them one at a time. An encoder with two priorities swapped would report the wrong code at one of those steps. It tests the character timeout with only enable bit 0 set, so a design that gave the timeout its own enable would stay silent there. It holds the FIFO count one below the trigger level and then exactly at it, which catches an off-by-one comparison. It reads the identification byte while line status masks the transmit-empty code, so a design that cleared the pending state on every read would lose the transmit-empty interrupt once the line error goes away. A set and a clear event in the same cycle confirm that the set wins.

// File: rtl/uart_iid_pkg.sv
package uart_iid_pkg;

    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_LINE,
        SRC_TMO,
        SRC_RXD,
        SRC_TXE,
        SRC_MDM
    } src_e;

    typedef enum logic {
        TXE_IDLE,
        TXE_PENDING
    } txe_state_e;

    localparam logic [3:0] CODE_NONE = 4'h1;
    localparam logic [3:0] CODE_LINE = 4'h6;
    localparam logic [3:0] CODE_TMO  = 4'hC;
    localparam logic [3:0] CODE_RXD  = 4'h4;
    localparam logic [3:0] CODE_TXE  = 4'h2;
    localparam logic [3:0] CODE_MDM  = 4'h0;

    // enable register bit positions
    localparam int EN_RXD  = 0;
    localparam int EN_TXE  = 1;
    localparam int EN_LINE = 2;
    localparam int EN_MDM  = 3;

endpackage

// File: rtl/iid_txe_tracker.sv
module iid_txe_tracker
    import uart_iid_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_ev,
    input  logic clr_ev,
    output logic pending
);

    txe_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TXE_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TXE_IDLE:    if (set_ev) state_d = TXE_PENDING;
            TXE_PENDING: if (clr_ev && !set_ev) state_d = TXE_IDLE;
            default:     state_d = TXE_IDLE;
        endcase
    end

    always_comb pending = (state_q == TXE_PENDING);

    // R12: a set event always leaves the tracker pending
    p_set_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        set_ev |=> pending);

    // R8: a clear without a set empties the tracker
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ev && !set_ev) |=> !pending);

endmodule

// File: rtl/iid_src_select.sv
module iid_src_select
    import uart_iid_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       ier,
    input  logic [3:0]       line_err,
    input  logic             rx_ready,
    input  logic             char_tmo,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] rx_trig,
    input  logic             txe_pending,
    input  logic [3:0]       modem_delta,
    input  logic             fifo_en,
    output src_e             src
);

    logic line_hit, tmo_hit, rxd_hit, txe_hit, mdm_hit, level_ok;

    always_comb begin
        level_ok = !fifo_en || (rx_count >= rx_trig);
        line_hit = ier[EN_LINE] && (|line_err);
        tmo_hit  = ier[EN_RXD] && char_tmo;
        rxd_hit  = ier[EN_RXD] && rx_ready && level_ok;
        txe_hit  = ier[EN_TXE] && txe_pending;
        mdm_hit  = ier[EN_MDM] && (|modem_delta);
    end

    always_comb begin
        if (line_hit)     src = SRC_LINE;
        else if (tmo_hit) src = SRC_TMO;
        else if (rxd_hit) src = SRC_RXD;
        else if (txe_hit) src = SRC_TXE;
        else if (mdm_hit) src = SRC_MDM;
        else              src = SRC_NONE;
    end

    // R2 / R4: enabled line error always wins
    p_line_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ier[2] && line_err != 4'h0) |-> src == SRC_LINE);

    // R10: modem reported only with its enable and a delta, nothing above it
    p_modem_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_MDM) |-> (ier[3] && modem_delta != 4'h0 && !rx_ready_gate()));

    function automatic logic rx_ready_gate();
        return (ier[0] && (char_tmo || (rx_ready && level_ok))) ||
               (ier[2] && line_err != 4'h0) || (ier[1] && txe_pending);
    endfunction

endmodule

// File: rtl/uart_iid_prio.sv
module uart_iid_prio
    import uart_iid_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int CNT_W      = $clog2(FIFO_DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ier_wr,
    input  logic [7:0]       ier_wdata,
    input  logic             iir_rd,
    input  logic [3:0]       line_err,
    input  logic             rx_ready,
    input  logic             char_tmo,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] rx_trig,
    input  logic             thr_empty,
    input  logic             txe_raise,
    input  logic             txe_drop,
    input  logic [3:0]       modem_delta,
    input  logic             fifo_en,
    output logic [3:0]       ier_q,
    output logic [7:0]       iir_q,
    output logic             irq
);

    src_e       src;
    logic       txe_pending;
    logic       set_ev, clr_ev;
    logic [3:0] code;

    always_ff @(posedge clk) begin
        if (!rst_n)      ier_q <= 4'h0;
        else if (ier_wr) ier_q <= ier_wdata[3:0];
    end

    always_comb begin
        set_ev = txe_raise || (ier_wr && thr_empty);
        clr_ev = txe_drop  || (iir_rd && src == SRC_TXE);
    end

    iid_txe_tracker u_txe (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_ev  (set_ev),
        .clr_ev  (clr_ev),
        .pending (txe_pending)
    );

    iid_src_select #(.CNT_W(CNT_W)) u_sel (
        .clk         (clk),
        .rst_n       (rst_n),
        .ier         (ier_q),
        .line_err    (line_err),
        .rx_ready    (rx_ready),
        .char_tmo    (char_tmo),
        .rx_count    (rx_count),
        .rx_trig     (rx_trig),
        .txe_pending (txe_pending),
        .modem_delta (modem_delta),
        .fifo_en     (fifo_en),
        .src         (src)
    );

    always_comb begin
        unique case (src)
            SRC_LINE: code = CODE_LINE;
            SRC_TMO:  code = CODE_TMO;
            SRC_RXD:  code = CODE_RXD;
            SRC_TXE:  code = CODE_TXE;
            SRC_MDM:  code = CODE_MDM;
            default:  code = CODE_NONE;
        endcase
    end

    always_comb begin
        iir_q = {{2{fifo_en}}, 2'b00, code};
        irq   = (src != SRC_NONE);
    end

    // R11: request and identification byte agree
    p_irq_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (iir_q[3:0] != 4'h1));

    // R9: only the low nibble of a write is kept
    p_ier_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ier_wr |=> ({4'h0, ier_q} == ($past(ier_wdata) & 8'h0F)));

    // R9: write with empty holding register arms the transmit-empty source
    p_ier_arm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_wr && thr_empty) |=> txe_pending);

endmodule

// File: tb/uart_iid_prio_tb.sv
module uart_iid_prio_tb;

    localparam int CNT_W = 5;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             ier_wr;
    logic [7:0]       ier_wdata;
    logic             iir_rd;
    logic [3:0]       line_err;
    logic             rx_ready;
    logic             char_tmo;
    logic [CNT_W-1:0] rx_count;
    logic [CNT_W-1:0] rx_trig;
    logic             thr_empty;
    logic             txe_raise;
    logic             txe_drop;
    logic [3:0]       modem_delta;
    logic             fifo_en;
    logic [3:0]       ier_q;
    logic [7:0]       iir_q;
    logic             irq;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    uart_iid_prio #(.FIFO_DEPTH(16), .CNT_W(CNT_W)) u_dut (.*);

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
        end
    endtask

    // code check with request consistency (R11)
    task automatic chk_iid(input string tag, input logic [7:0] exp);
        #1;
        chk(tag, iir_q, exp);
        chk({tag, " R11"}, {7'd0, irq}, {7'd0, (exp[3:0] != 4'h1)});
    endtask

    task automatic clear_inputs();
        ier_wr = 0; ier_wdata = 0; iir_rd = 0; line_err = 0; rx_ready = 0;
        char_tmo = 0; rx_count = 0; rx_trig = 0; thr_empty = 0;
        txe_raise = 0; txe_drop = 0; modem_delta = 0; fifo_en = 0;
    endtask

    task automatic write_ier(input logic [7:0] v, input logic empty);
        @(negedge clk);
        ier_wr = 1; ier_wdata = v; thr_empty = empty;
        @(negedge clk);
        ier_wr = 0; thr_empty = 0;
    endtask

    task automatic pulse_rd();
        @(negedge clk); iir_rd = 1;
        @(negedge clk); iir_rd = 0;
    endtask

    task automatic t_reset();
        #1;
        chk("R1 iir", iir_q, 8'h01);
        chk("R1 irq", {7'd0, irq}, 8'h00);
        chk("R1 ier", {4'd0, ier_q}, 8'h00);
        write_ier(8'h02, 1'b0);
        chk_iid("R1 no pending txe", 8'h01);
        write_ier(8'h00, 1'b0);
    endtask

    task automatic t_priority();
        write_ier(8'h0F, 1'b0);
        @(negedge clk);
        line_err = 4'b0100; char_tmo = 1; rx_ready = 1; modem_delta = 4'b0010;
        txe_raise = 1;
        @(negedge clk); txe_raise = 0;
        chk_iid("R2 R3 line", 8'h06);
        line_err = 0;          chk_iid("R2 R3 timeout", 8'h0C);
        char_tmo = 0;          chk_iid("R2 R3 rxdata", 8'h04);
        rx_ready = 0;          chk_iid("R2 R3 txempty", 8'h02);
        @(negedge clk); txe_drop = 1;
        @(negedge clk); txe_drop = 0;
        chk_iid("R12 drop R3 modem", 8'h00);
        modem_delta = 0;       chk_iid("R3 none", 8'h01);
    endtask

    task automatic t_masks();
        write_ier(8'h00, 1'b0);
        @(negedge clk);
        line_err = 4'hF; char_tmo = 1; rx_ready = 1; modem_delta = 4'hF;
        chk_iid("R4 R10 all masked", 8'h01);
        write_ier(8'h0B, 1'b0);
        line_err = 4'b0001; char_tmo = 0; rx_ready = 0;
        chk_iid("R4 line needs bit2", 8'h00);
        modem_delta = 0;
        chk_iid("R10 no delta", 8'h01);
        write_ier(8'h01, 1'b0);
        char_tmo = 1;
        chk_iid("R5 timeout via bit0", 8'h0C);
        write_ier(8'h0E, 1'b0);
        line_err = 0;
        chk_iid("R5 timeout masked", 8'h01);
        char_tmo = 0;
    endtask

    task automatic t_fifo();
        write_ier(8'h01, 1'b0);
        @(negedge clk);
        fifo_en = 1; rx_ready = 1; rx_trig = 5'd4; rx_count = 5'd3;
        chk_iid("R6 below trigger R7", 8'hC1);
        rx_count = 5'd4;
        chk_iid("R6 at trigger", 8'hC4);
        fifo_en = 0; rx_count = 5'd0;
        chk_iid("R6 R7 no fifo", 8'h04);
        rx_ready = 0;
    endtask

    task automatic t_read_clear();
        write_ier(8'h06, 1'b1);
        chk_iid("R9 arm on write", 8'h02);
        pulse_rd();
        chk_iid("R8 read clears", 8'h01);
        @(negedge clk); txe_raise = 1;
        @(negedge clk); txe_raise = 0;
        line_err = 4'b1000;
        chk_iid("R8 line masks txe", 8'h06);
        pulse_rd();
        line_err = 0;
        chk_iid("R8 other code keeps", 8'h02);
        @(negedge clk); iir_rd = 1; txe_raise = 1;
        @(negedge clk); iir_rd = 0; txe_raise = 0;
        chk_iid("R12 set wins", 8'h02);
        @(negedge clk); txe_drop = 1;
        @(negedge clk); txe_drop = 0;
    endtask

    task automatic t_ier_write();
        write_ier(8'hF5, 1'b0);
        #1;
        chk("R9 low nibble", {4'd0, ier_q}, 8'h05);
        chk_iid("R9 no arm when busy", 8'h01);
    endtask

    initial begin
        clear_inputs();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_priority();
        t_masks();
        t_fifo();
        t_read_clear();
        t_ier_write();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #100000;
        checks++; fails++;
        $display("FAIL watchdog got=hung exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule